// File: doc/BRIEF.md
# Byte-Lane Swap Steering Unit

This block routes the two byte lanes of a 16-bit master data bus to and from a target bus. The resource on the target bus may be 8 bits or 16 bits wide. At the start of each transfer the block registers the cycle attributes: the cycle kind, the direction, the address parity, whether a whole word is requested, the target width, and whether source and destination both sit on the expansion bus. From these registered attributes it derives the lane output enables for both sides and the swap multiplexers. The control decode is combinational, so the enables are valid from the clock edge that registered the attributes until the cycle is ended.

A 16-bit resource uses its low lane for even-addressed bytes and its high lane for odd-addressed bytes. An 8-bit resource uses only its low lane. When an odd-addressed byte moves between the two sides, the block crosses the lanes. It applies the same rule to CPU I/O, CPU memory, DMA and bus-master cycles, in both directions. In a DMA or master transfer where both ends are on the expansion bus, the block takes the byte from the source lane on the target bus and drives it back onto the destination lane. Read data for the master side is held in a register that loads on a capture strobe.

Top module: `laneSteer`

## Requirements
- R1: While reset is asserted and after it is released, with no cycle started: all four lane enables are low, `unsupported` and `swapActive` are low and `masterDataOut` is zero.
- R2: A write to a 16-bit target passes data straight through. A word write enables both target lanes. A byte write with `addrLsb`=0 enables only `targetLoOe`. A byte write with `addrLsb`=1 enables only `targetHiOe`.
- R3: A byte write to an 8-bit target enables only `targetLoOe`. `targetDataOut[7:0]` is `masterDataIn[15:8]` when `addrLsb`=1 and `masterDataIn[7:0]` when `addrLsb`=0.
- R4: A read from a 16-bit target captures `targetDataIn` straight into the selected lanes of `masterDataOut`: both lanes for a word, the low lane for an even byte, the high lane for an odd byte. The matching master-side enables are high.
- R5: A byte read from an 8-bit target at an odd address enables only `masterHiOe`, and the capture stores `targetDataIn[7:0]` in `masterDataOut[15:8]`. At an even address it enables only `masterLoOe` and stores the same byte in `masterDataOut[7:0]`.
- R6: `masterDataOut` changes only on a `captureStrobe` edge. Lanes that the current cycle does not select keep their previous value. A strobe while no read cycle is active leaves the register unchanged.
- R7: A word request (`wordReq`=1) to an 8-bit target raises `unsupported`, keeps all four enables low and ignores `captureStrobe`.
- R8: In a DMA (`cycleKind`=2) or master (`cycleKind`=3) cycle with `expLoop`=1, an 8-bit target and `addrLsb`=1, the block drives back onto the target bus. With `dirRead`=1 (8-bit source) it enables only `targetHiOe` with `targetDataOut[15:8]`=`targetDataIn[7:0]`. With `dirRead`=0 (16-bit source) it enables only `targetLoOe` with `targetDataOut[7:0]`=`targetDataIn[15:8]`. With an even address or a 16-bit target, it enables no lane.
- R9: `expLoop` has no effect in CPU I/O (`cycleKind`=0) and CPU memory (`cycleKind`=1) cycles; they behave as normal transfers.
- R10: The lane rules of R2 to R5 are the same for all four cycle kinds.
- R11: No master-side enable is ever high together with a target-side enable. `swapActive` is high exactly when a lane crossing is in use, and then exactly one enable is high.
- R12: The enables follow the attributes registered by `cycleStart` from the next clock edge. `cycleEnd` clears all enables and `unsupported` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStart | input | 1 | Register the cycle attributes and begin a cycle |
| cycleEnd | input | 1 | End the current cycle |
| cycleKind | input | 2 | 0 CPU I/O, 1 CPU memory, 2 DMA, 3 bus master |
| dirRead | input | 1 | 1 = data moves toward the master (or from the 8-bit source in loopback) |
| addrLsb | input | 1 | Address bit 0 |
| wordReq | input | 1 | 1 = word access, 0 = single byte |
| wideTgt | input | 1 | 1 = target resource is 16 bits wide |
| expLoop | input | 1 | Source and destination both on the expansion bus |
| captureStrobe | input | 1 | Load the read register |
| masterDataIn | input | 16 | Write data from the master side |
| targetDataIn | input | 16 | Data sampled from the target bus |
| masterDataOut | output | 16 | Registered read data for the master side |
| targetDataOut | output | 16 | Steered data for the target bus |
| masterLoOe | output | 1 | Drive master lane 0 |
| masterHiOe | output | 1 | Drive master lane 1 |
| targetLoOe | output | 1 | Drive target lane 0 |
| targetHiOe | output | 1 | Drive target lane 1 |
| swapActive | output | 1 | A lane crossing is in use |
| unsupported | output | 1 | Word request to an 8-bit target |

## Verification
A wrong registered attribute shows at the enable ports in the first cycle after `cycleStart`, because those ports are a purely combinational decode of the attribute register. A faulty swap select shows at once on `targetDataOut` for writes and loopback transfers. For reads it shows on `masterDataOut` one edge after the capture strobe. A faulty per-lane capture enable shows only later: the stale or overwritten unselected lane is visible after the next capture, so the bench reads both lanes after every strobe.

// File: rtl/laneSteerPkg.sv
package laneSteerPkg;

  typedef enum logic [1:0] {
    KIND_CPU_IO  = 2'b00,
    KIND_CPU_MEM = 2'b01,
    KIND_DMA     = 2'b10,
    KIND_MASTER  = 2'b11
  } cycleKindT;

  // attributes latched at cycle start
  typedef struct packed {
    cycleKindT kind;
    logic      dirRead;
    logic      oddAddr;
    logic      wordReq;
    logic      wideTgt;
    logic      expLoop;
  } cycleAttrT;

  // strobes from control to datapath
  typedef struct packed {
    logic tgtLoOe;
    logic tgtHiOe;
    logic mstLoOe;
    logic mstHiOe;
    logic swapLoToHi;   // target lane 0 -> master lane 1 (read)
    logic swapHiToLo;   // master lane 1 -> target lane 0 (write)
    logic loopLoToHi;   // target lane 0 -> target lane 1
    logic loopHiToLo;   // target lane 1 -> target lane 0
    logic unsupported;
  } laneCtlT;

endpackage

// File: rtl/laneSteerCtrl.sv
module laneSteerCtrl
  import laneSteerPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cycleStart,
  input  logic      cycleEnd,
  input  cycleAttrT attrIn,
  output laneCtlT   ctl
);

  cycleAttrT attrQ;
  logic      activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrQ   <= '0;
      activeQ <= 1'b0;
    end else if (cycleStart) begin
      attrQ   <= attrIn;
      activeQ <= 1'b1;
    end else if (cycleEnd) begin
      activeQ <= 1'b0;
    end
  end

  logic narrow, odd, loopKind, loopOk, unsup, normal, isWrite, isRead;
  logic laneLo, laneHi, loopSwap;

  always_comb begin
    narrow   = !attrQ.wideTgt;
    odd      = attrQ.oddAddr;
    loopKind = (attrQ.kind == KIND_DMA) || (attrQ.kind == KIND_MASTER);
    loopOk   = attrQ.expLoop && loopKind;
    unsup    = activeQ && narrow && attrQ.wordReq;
    normal   = activeQ && !unsup && !loopOk;
    isWrite  = normal && !attrQ.dirRead;
    isRead   = normal && attrQ.dirRead;
    laneLo   = attrQ.wordReq || !odd;
    laneHi   = attrQ.wordReq || odd;
    loopSwap = activeQ && !unsup && loopOk && narrow && odd;

    ctl = '0;
    ctl.unsupported = unsup;
    if (isWrite) begin
      ctl.tgtLoOe    = narrow ? 1'b1 : laneLo;
      ctl.tgtHiOe    = narrow ? 1'b0 : laneHi;
      ctl.swapHiToLo = narrow && odd;
    end
    if (isRead) begin
      ctl.mstLoOe    = narrow ? !odd : laneLo;
      ctl.mstHiOe    = narrow ? odd  : laneHi;
      ctl.swapLoToHi = narrow && odd;
    end
    if (loopSwap) begin
      ctl.loopLoToHi = attrQ.dirRead;
      ctl.loopHiToLo = !attrQ.dirRead;
      ctl.tgtHiOe    = attrQ.dirRead;
      ctl.tgtLoOe    = !attrQ.dirRead;
    end
  end

endmodule

// File: rtl/laneSteerData.sv
module laneSteerData
  import laneSteerPkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int LANES  = 2,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtlT           ctl,
  input  logic              captureStrobe,
  input  logic [DATA_W-1:0] masterDataIn,
  input  logic [DATA_W-1:0] targetDataIn,
  output logic [DATA_W-1:0] masterDataOut,
  output logic [DATA_W-1:0] targetDataOut
);

  logic [BYTE_W-1:0] mIn  [LANES];
  logic [BYTE_W-1:0] tIn  [LANES];
  logic [BYTE_W-1:0] rdSt [LANES];
  logic [BYTE_W-1:0] wrSt [LANES];
  logic              capEn[LANES];

  always_comb begin
    // write / loopback toward the target bus
    if (ctl.loopHiToLo)      wrSt[0] = tIn[1];
    else if (ctl.swapHiToLo) wrSt[0] = mIn[1];
    else                     wrSt[0] = mIn[0];
    wrSt[1] = ctl.loopLoToHi ? tIn[0] : mIn[1];
    // read toward the master bus
    rdSt[0] = tIn[0];
    rdSt[1] = ctl.swapLoToHi ? tIn[0] : tIn[1];
    capEn[0] = captureStrobe && ctl.mstLoOe;
    capEn[1] = captureStrobe && ctl.mstHiOe;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BYTE_W-1:0] capQ;

    assign mIn[g] = masterDataIn[g*BYTE_W +: BYTE_W];
    assign tIn[g] = targetDataIn[g*BYTE_W +: BYTE_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         capQ <= '0;
      else if (capEn[g]) capQ <= rdSt[g];
    end

    assign masterDataOut[g*BYTE_W +: BYTE_W] = capQ;
    assign targetDataOut[g*BYTE_W +: BYTE_W] = wrSt[g];
  end

endmodule

// File: rtl/laneSteer.sv
module laneSteer
  import laneSteerPkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStart,
  input  logic              cycleEnd,
  input  logic [1:0]        cycleKind,
  input  logic              dirRead,
  input  logic              addrLsb,
  input  logic              wordReq,
  input  logic              wideTgt,
  input  logic              expLoop,
  input  logic              captureStrobe,
  input  logic [DATA_W-1:0] masterDataIn,
  input  logic [DATA_W-1:0] targetDataIn,
  output logic [DATA_W-1:0] masterDataOut,
  output logic [DATA_W-1:0] targetDataOut,
  output logic              masterLoOe,
  output logic              masterHiOe,
  output logic              targetLoOe,
  output logic              targetHiOe,
  output logic              swapActive,
  output logic              unsupported
);

  cycleAttrT attrIn;
  laneCtlT   ctl;

  always_comb begin
    attrIn.kind    = cycleKindT'(cycleKind);
    attrIn.dirRead = dirRead;
    attrIn.oddAddr = addrLsb;
    attrIn.wordReq = wordReq;
    attrIn.wideTgt = wideTgt;
    attrIn.expLoop = expLoop;
  end

  laneSteerCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .cycleEnd(cycleEnd),
    .attrIn(attrIn), .ctl(ctl)
  );

  laneSteerData #(.BYTE_W(BYTE_W)) i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .captureStrobe(captureStrobe),
    .masterDataIn(masterDataIn), .targetDataIn(targetDataIn),
    .masterDataOut(masterDataOut), .targetDataOut(targetDataOut)
  );

  assign masterLoOe  = ctl.mstLoOe;
  assign masterHiOe  = ctl.mstHiOe;
  assign targetLoOe  = ctl.tgtLoOe;
  assign targetHiOe  = ctl.tgtHiOe;
  assign unsupported = ctl.unsupported;
  assign swapActive  = ctl.swapLoToHi | ctl.swapHiToLo | ctl.loopLoToHi | ctl.loopHiToLo;

endmodule

// File: rtl/laneSteerChk.sv
module laneSteerChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycleStart,
  input logic              cycleEnd,
  input logic              captureStrobe,
  input logic [DATA_W-1:0] masterDataOut,
  input logic              masterLoOe,
  input logic              masterHiOe,
  input logic              targetLoOe,
  input logic              targetHiOe,
  input logic              swapActive,
  input logic              unsupported
);

  logic [3:0] oeVec;
  assign oeVec = {targetLoOe, targetHiOe, masterLoOe, masterHiOe};

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_idle_r1: assert (oeVec == 4'b0 && !unsupported && !swapActive && masterDataOut == '0)
        else $error("reset state not idle");
    end
  end

  p_unsup_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> (oeVec == 4'b0));

  p_no_contention_r11: assert property (@(posedge clk) disable iff (!rstN)
    !((targetLoOe || targetHiOe) && (masterLoOe || masterHiOe)));

  p_swap_one_lane_r11: assert property (@(posedge clk) disable iff (!rstN)
    swapActive |-> ($countones(oeVec) == 1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !captureStrobe |=> $stable(masterDataOut));

  p_end_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEnd && !cycleStart) |=> (oeVec == 4'b0 && !unsupported));

endmodule

bind laneSteer laneSteerChk #(.DATA_W(DATA_W)) i_laneSteerChk (
  .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .cycleEnd(cycleEnd),
  .captureStrobe(captureStrobe), .masterDataOut(masterDataOut),
  .masterLoOe(masterLoOe), .masterHiOe(masterHiOe),
  .targetLoOe(targetLoOe), .targetHiOe(targetHiOe),
  .swapActive(swapActive), .unsupported(unsupported)
);

// File: tb/test_laneSteer.sv
module test_laneSteer;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStart = 0, cycleEnd = 0, dirRead = 0, addrLsb = 0, wordReq = 0;
  logic wideTgt = 0, expLoop = 0, captureStrobe = 0;
  logic [1:0]  cycleKind = 0;
  logic [15:0] masterDataIn = 0, targetDataIn = 0;
  logic [15:0] masterDataOut, targetDataOut;
  logic masterLoOe, masterHiOe, targetLoOe, targetHiOe, swapActive, unsupported;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [15:0] expRd = 16'h0000;

  always #(PERIOD/2) clk = ~clk;

  laneSteer i_laneSteer (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .cycleEnd(cycleEnd),
    .cycleKind(cycleKind), .dirRead(dirRead), .addrLsb(addrLsb), .wordReq(wordReq),
    .wideTgt(wideTgt), .expLoop(expLoop), .captureStrobe(captureStrobe),
    .masterDataIn(masterDataIn), .targetDataIn(targetDataIn),
    .masterDataOut(masterDataOut), .targetDataOut(targetDataOut),
    .masterLoOe(masterLoOe), .masterHiOe(masterHiOe),
    .targetLoOe(targetLoOe), .targetHiOe(targetHiOe),
    .swapActive(swapActive), .unsupported(unsupported)
  );

  task automatic checkVal(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // enables packed as {tLo,tHi,mLo,mHi}
  task automatic checkOe(string req, logic [3:0] exp);
    checkVal(req, {28'b0, targetLoOe, targetHiOe, masterLoOe, masterHiOe}, {28'b0, exp});
  endtask

  task automatic startCycle(logic [1:0] k, logic rd, logic odd, logic wd, logic wide, logic lp);
    @(negedge clk);
    cycleKind = k; dirRead = rd; addrLsb = odd; wordReq = wd; wideTgt = wide; expLoop = lp;
    cycleStart = 1;
    @(negedge clk);
    cycleStart = 0;
  endtask

  task automatic endCycle();
    @(negedge clk);
    cycleEnd = 1;
    @(negedge clk);
    cycleEnd = 0;
  endtask

  task automatic capture(logic [15:0] d);
    @(negedge clk);
    targetDataIn = d;
    captureStrobe = 1;
    @(negedge clk);
    captureStrobe = 0;
  endtask

  task automatic tReset();
    checkOe("R1 enables", 4'b0000);
    checkVal("R1 flags", {30'b0, unsupported, swapActive}, 32'h0);
    checkVal("R1 readData", {16'b0, masterDataOut}, 32'h0);
  endtask

  task automatic tWideWrite();
    masterDataIn = 16'hA55A;
    startCycle(2'd1, 0, 0, 1, 1, 0);
    checkOe("R2 word enables", 4'b1100);
    checkVal("R2 word data", {16'b0, targetDataOut}, 32'hA55A);
    endCycle();
    startCycle(2'd0, 0, 1, 0, 1, 0);
    checkOe("R2 odd byte enables", 4'b0100);
    checkVal("R2 odd byte data", {24'b0, targetDataOut[15:8]}, 32'hA5);
    endCycle();
    startCycle(2'd3, 0, 0, 0, 1, 0);
    checkOe("R2 R10 even byte master kind", 4'b1000);
    checkVal("R2 even byte data", {24'b0, targetDataOut[7:0]}, 32'h5A);
    endCycle();
    checkOe("R12 cleared after end", 4'b0000);
  endtask

  task automatic tNarrowWrite();
    masterDataIn = 16'h3CC3;
    startCycle(2'd2, 0, 1, 0, 0, 0);
    checkOe("R3 odd narrow enables", 4'b1000);
    checkVal("R3 odd narrow data", {24'b0, targetDataOut[7:0]}, 32'h3C);
    checkVal("R11 swapActive odd narrow write", {31'b0, swapActive}, 32'h1);
    endCycle();
    startCycle(2'd3, 0, 0, 0, 0, 0);
    checkOe("R3 even narrow enables", 4'b1000);
    checkVal("R3 even narrow data", {24'b0, targetDataOut[7:0]}, 32'hC3);
    checkVal("R11 no swap even", {31'b0, swapActive}, 32'h0);
    endCycle();
  endtask

  task automatic tWideRead();
    startCycle(2'd1, 1, 0, 1, 1, 0);
    checkOe("R4 word read enables", 4'b0011);
    capture(16'h1234);
    expRd = 16'h1234;
    checkVal("R4 word read data", {16'b0, masterDataOut}, {16'b0, expRd});
    endCycle();
    startCycle(2'd2, 1, 1, 0, 1, 0);
    checkOe("R4 R10 odd wide read enables", 4'b0001);
    capture(16'hBE77);
    expRd[15:8] = 8'hBE;
    checkVal("R4 R6 odd wide read data", {16'b0, masterDataOut}, {16'b0, expRd});
    endCycle();
  endtask

  task automatic tNarrowRead();
    startCycle(2'd0, 1, 1, 0, 0, 0);
    checkOe("R5 odd narrow read enables", 4'b0001);
    capture(16'h99E1);
    expRd[15:8] = 8'hE1;
    checkVal("R5 R6 odd narrow read data", {16'b0, masterDataOut}, {16'b0, expRd});
    endCycle();
    startCycle(2'd3, 1, 0, 0, 0, 0);
    checkOe("R5 even narrow read enables", 4'b0010);
    capture(16'h8842);
    expRd[7:0] = 8'h42;
    checkVal("R5 even narrow read data", {16'b0, masterDataOut}, {16'b0, expRd});
    endCycle();
    capture(16'hFFFF);
    checkVal("R6 strobe while idle", {16'b0, masterDataOut}, {16'b0, expRd});
  endtask

  task automatic tUnsupported();
    startCycle(2'd1, 1, 0, 1, 0, 0);
    checkVal("R7 flag", {31'b0, unsupported}, 32'h1);
    checkOe("R7 enables", 4'b0000);
    capture(16'h0F0F);
    checkVal("R7 strobe ignored", {16'b0, masterDataOut}, {16'b0, expRd});
    endCycle();
    checkVal("R12 flag cleared", {31'b0, unsupported}, 32'h0);
  endtask

  task automatic tLoop();
    targetDataIn = 16'h7E18;
    startCycle(2'd2, 1, 1, 0, 0, 1);
    checkOe("R8 loop lo-to-hi enables", 4'b0100);
    checkVal("R8 loop lo-to-hi data", {24'b0, targetDataOut[15:8]}, 32'h18);
    endCycle();
    startCycle(2'd3, 0, 1, 0, 0, 1);
    checkOe("R8 loop hi-to-lo enables", 4'b1000);
    checkVal("R8 loop hi-to-lo data", {24'b0, targetDataOut[7:0]}, 32'h7E);
    endCycle();
    startCycle(2'd2, 1, 0, 0, 0, 1);
    checkOe("R8 loop even none", 4'b0000);
    endCycle();
    startCycle(2'd3, 1, 1, 0, 1, 1);
    checkOe("R8 loop wide none", 4'b0000);
    endCycle();
  endtask

  task automatic tCpuIgnoresLoop();
    masterDataIn = 16'hD00B;
    startCycle(2'd1, 0, 1, 0, 0, 1);
    checkOe("R9 cpu mem loop ignored enables", 4'b1000);
    checkVal("R9 cpu mem loop ignored data", {24'b0, targetDataOut[7:0]}, 32'hD0);
    endCycle();
    startCycle(2'd0, 1, 1, 0, 0, 1);
    checkOe("R9 cpu io loop ignored read", 4'b0001);
    endCycle();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 2 + 1);
    tReset();
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tWideWrite();
    tNarrowWrite();
    tWideRead();
    tNarrowRead();
    tUnsupported();
    tLoop();
    tCpuIgnoresLoop();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule